// File: doc/BRIEF.md
# Function-Unit to Register Dependency Matrix

This block tracks, for a set of function-unit rows, which architectural registers each row still has to read and which register it will write. Register identities are kept as expanded one-hot wires, one per register, rather than encoded indices. When an operation is issued to a row, the row latches a one-hot mask for each of its two sources and one for its destination. It then collects copies of its source values from the register file through a single shared read port. Because each row holds its own operand copies, several rows can sit in front of one ALU and act as reservation stations.

Each row runs a three-state machine. `ROW_IDLE` moves to `ROW_WAIT` on an issue that names at least one source, and moves straight to `ROW_READY` on an issue that names none. `ROW_WAIT` moves to `ROW_READY` when the last needed operand is captured, and back to `ROW_IDLE` on a kill. `ROW_READY` moves to `ROW_IDLE` on a writeback or a kill.

The matrix ORs the rows into per-register pending-write and pending-read vectors. From these it chooses which register to read each cycle, and it reports per-row "operands ready" flags. The ALU, the unit-to-unit ordering matrix and the register storage are outside the block. The register file answers `rd_oh` combinationally on `rd_data`.

Top module: `fu_reg_depmatrix`

## Requirements
- R1: After reset every row is idle, `pend_wr`, `pend_rd` and `ops_ready` are all zero, and `rd_valid` is low.
- R2: A pulse of `iss_valid` to an idle row latches `iss_src_a`, `iss_src_b` and `iss_dst`. Each is one-hot, and all-zero means "none". From the next cycle the destination shows in `pend_wr`, and sources not yet captured show in `pend_rd`. An issue to a row that is not idle is ignored, and its masks and operands stay as they were.
- R3: Bit k of `pend_wr` is the OR over rows of each row's need-write bit k. Bit k of `pend_rd` is the OR over rows of each row's uncaptured source bits at position k.
- R4: In any cycle where some waiting row has an unblocked uncaptured source, `rd_valid` is high and `rd_oh` carries exactly one bit. It selects the lowest-numbered such row, and within that row source A comes before source B. `rd_data` is captured at the next clock edge.
- R5: A source of row r on register k is blocked while any other row has a need-write bit on k. The row's own destination never blocks its own sources.
- R6: One read is captured into every source slot, in every waiting row, that needs the register on `rd_oh` and is not blocked for that row. The captured values appear on `sel_opnd_a`/`sel_opnd_b` when `sel_row` picks the row. A source slot marked "none" reads zero.
- R7: `ops_ready[r]` is high while row r is in `ROW_READY`. That state begins the cycle after the last capture, or the cycle after an issue with no sources, and lasts until a writeback or a kill.
- R8: `wb_valid` with `wb_row` on a ready row returns the row to idle. Its destination leaves `pend_wr` in the same cycle that `wb_valid` is high. A writeback to a row that is not ready is ignored.
- R9: `kill_valid` with `kill_row` on a waiting or ready row returns it to idle. Its destination leaves `pend_wr` in the same cycle, and its uncaptured sources leave `pend_rd` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue an operation this cycle |
| iss_row | input | log2(NUM_ROWS) | Row receiving the issue |
| iss_src_a | input | NUM_REGS | One-hot first source register, zero for none |
| iss_src_b | input | NUM_REGS | One-hot second source register, zero for none |
| iss_dst | input | NUM_REGS | One-hot destination register, zero for none |
| wb_valid | input | 1 | Writeback of a row this cycle |
| wb_row | input | log2(NUM_ROWS) | Row being written back |
| kill_valid | input | 1 | Kill a row this cycle |
| kill_row | input | log2(NUM_ROWS) | Row being killed |
| rd_valid | output | 1 | Register read request active |
| rd_oh | output | NUM_REGS | One-hot register being read |
| rd_data | input | DATA_W | Value of the register on rd_oh |
| sel_row | input | log2(NUM_ROWS) | Row whose operand copies are shown |
| sel_opnd_a | output | DATA_W | Captured first operand of sel_row |
| sel_opnd_b | output | DATA_W | Captured second operand of sel_row |
| pend_wr | output | NUM_REGS | Registers with an outstanding write |
| pend_rd | output | NUM_REGS | Registers with an outstanding read |
| ops_ready | output | NUM_ROWS | Per-row all-operands-captured flag |

## Verification
A sequence of issues, writebacks and kills is applied. After each one the bench lets the reads settle and then checks the pending vectors, the ready flags and one row's operand copies. The sequence includes:
- Sources that are free, which separates plain capture from blocking.
- A source waiting on another row's destination, which shows that R5 is being enforced.
- A row whose own destination equals its source, which must not stall.
- Issues and writebacks aimed at rows in the wrong state, which must leave every output unchanged.

A directed case blocks two rows on two different writers and frees both writers in one cycle. This shows the row-priority order of the read port and the broadcast capture into two rows. Probing `pend_wr` before the clock edge separates a same-cycle release from a registered one.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        ROW_IDLE  = 2'd0,
        ROW_WAIT  = 2'd1,
        ROW_READY = 2'd2
    } row_state_e;

endpackage

// File: rtl/dmx_row.sv
module dmx_row
    import dmx_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                iss_en,
    input  logic [NUM_REGS-1:0] iss_src_a,
    input  logic [NUM_REGS-1:0] iss_src_b,
    input  logic [NUM_REGS-1:0] iss_dst,
    input  logic                cap_a,
    input  logic                cap_b,
    input  logic [DATA_W-1:0]   cap_data,
    input  logic                wb_en,
    input  logic                kill_en,
    output row_state_e          state_o,
    output logic [NUM_REGS-1:0] need_a_o,
    output logic [NUM_REGS-1:0] need_b_o,
    output logic [NUM_REGS-1:0] need_wr_o,
    output logic [DATA_W-1:0]   opnd_a_o,
    output logic [DATA_W-1:0]   opnd_b_o
);

    row_state_e          state_q, state_d;
    logic [NUM_REGS-1:0] need_a_q, need_b_q, need_wr_q;
    logic [DATA_W-1:0]   opnd_a_q, opnd_b_q;
    logic                a_done, b_done;

    assign a_done = (need_a_q == '0) || cap_a;
    assign b_done = (need_b_q == '0) || cap_b;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ROW_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROW_IDLE: begin
                if (iss_en)
                    state_d = ((iss_src_a != '0) || (iss_src_b != '0)) ? ROW_WAIT : ROW_READY;
            end
            ROW_WAIT: begin
                if (kill_en)              state_d = ROW_IDLE;
                else if (a_done && b_done) state_d = ROW_READY;
            end
            ROW_READY: begin
                if (wb_en || kill_en) state_d = ROW_IDLE;
            end
            default: state_d = ROW_IDLE;
        endcase
    end

    // masks and operand copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            need_a_q  <= '0;
            need_b_q  <= '0;
            need_wr_q <= '0;
            opnd_a_q  <= '0;
            opnd_b_q  <= '0;
        end else begin
            unique case (state_q)
                ROW_IDLE: begin
                    if (iss_en) begin
                        need_a_q  <= iss_src_a;
                        need_b_q  <= iss_src_b;
                        need_wr_q <= iss_dst;
                        opnd_a_q  <= '0;
                        opnd_b_q  <= '0;
                    end
                end
                ROW_WAIT: begin
                    if (kill_en) begin
                        need_a_q  <= '0;
                        need_b_q  <= '0;
                        need_wr_q <= '0;
                    end else begin
                        if (cap_a) begin
                            need_a_q <= '0;
                            opnd_a_q <= cap_data;
                        end
                        if (cap_b) begin
                            need_b_q <= '0;
                            opnd_b_q <= cap_data;
                        end
                    end
                end
                ROW_READY: begin
                    if (wb_en || kill_en) need_wr_q <= '0;
                end
                default: begin
                    need_wr_q <= '0;
                end
            endcase
        end
    end

    // outputs
    assign state_o   = state_q;
    assign need_a_o  = need_a_q;
    assign need_b_o  = need_b_q;
    assign need_wr_o = need_wr_q;
    assign opnd_a_o  = opnd_a_q;
    assign opnd_b_o  = opnd_b_q;

endmodule

// File: rtl/dmx_pick.sv
module dmx_pick #(
    parameter int NUM_ROWS = 8,
    parameter int NUM_REGS = 32
) (
    input  logic [NUM_ROWS-1:0] elig_a,
    input  logic [NUM_ROWS-1:0] elig_b,
    input  logic [NUM_REGS-1:0] need_a [NUM_ROWS],
    input  logic [NUM_REGS-1:0] need_b [NUM_ROWS],
    output logic                rd_valid,
    output logic [NUM_REGS-1:0] rd_oh
);

    // walk from the top so the lowest eligible row is assigned last and wins
    always_comb begin
        rd_valid = 1'b0;
        rd_oh    = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (elig_a[r]) begin
                rd_valid = 1'b1;
                rd_oh    = need_a[r];
            end else if (elig_b[r]) begin
                rd_valid = 1'b1;
                rd_oh    = need_b[r];
            end
        end
    end

endmodule

// File: rtl/fu_reg_depmatrix.sv
module fu_reg_depmatrix
    import dmx_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int NUM_REGS = 32,
    parameter int DATA_W   = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [$clog2(NUM_ROWS)-1:0] iss_row,
    input  logic [NUM_REGS-1:0]         iss_src_a,
    input  logic [NUM_REGS-1:0]         iss_src_b,
    input  logic [NUM_REGS-1:0]         iss_dst,
    input  logic                        wb_valid,
    input  logic [$clog2(NUM_ROWS)-1:0] wb_row,
    input  logic                        kill_valid,
    input  logic [$clog2(NUM_ROWS)-1:0] kill_row,
    output logic                        rd_valid,
    output logic [NUM_REGS-1:0]         rd_oh,
    input  logic [DATA_W-1:0]           rd_data,
    input  logic [$clog2(NUM_ROWS)-1:0] sel_row,
    output logic [DATA_W-1:0]           sel_opnd_a,
    output logic [DATA_W-1:0]           sel_opnd_b,
    output logic [NUM_REGS-1:0]         pend_wr,
    output logic [NUM_REGS-1:0]         pend_rd,
    output logic [NUM_ROWS-1:0]         ops_ready
);

    localparam int ROW_W = $clog2(NUM_ROWS);

    row_state_e          st      [NUM_ROWS];
    logic [NUM_REGS-1:0] need_a  [NUM_ROWS];
    logic [NUM_REGS-1:0] need_b  [NUM_ROWS];
    logic [NUM_REGS-1:0] need_wr [NUM_ROWS];
    logic [NUM_REGS-1:0] blk     [NUM_ROWS];
    logic [DATA_W-1:0]   opa     [NUM_ROWS];
    logic [DATA_W-1:0]   opb     [NUM_ROWS];
    logic [NUM_ROWS-1:0] iss_en, wb_en, kill_en, rel;
    logic [NUM_ROWS-1:0] elig_a, elig_b, cap_a, cap_b;

    // per-row command decode
    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            iss_en[r]  = iss_valid  && (iss_row  == ROW_W'(r));
            wb_en[r]   = wb_valid   && (wb_row   == ROW_W'(r));
            kill_en[r] = kill_valid && (kill_row == ROW_W'(r));
            rel[r]     = (wb_en[r] && (st[r] == ROW_READY)) ||
                         (kill_en[r] && (st[r] != ROW_IDLE));
        end
    end

    // writes of every other row block a row's sources
    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            blk[r] = '0;
            for (int s = 0; s < NUM_ROWS; s++) begin
                if (s != r) blk[r] = blk[r] | need_wr[s];
            end
        end
    end

    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            elig_a[r] = (st[r] == ROW_WAIT) && (need_a[r] != '0) &&
                        ((need_a[r] & blk[r]) == '0);
            elig_b[r] = (st[r] == ROW_WAIT) && (need_b[r] != '0) &&
                        ((need_b[r] & blk[r]) == '0);
        end
    end

    dmx_pick #(
        .NUM_ROWS (NUM_ROWS),
        .NUM_REGS (NUM_REGS)
    ) u_pick (
        .elig_a   (elig_a),
        .elig_b   (elig_b),
        .need_a   (need_a),
        .need_b   (need_b),
        .rd_valid (rd_valid),
        .rd_oh    (rd_oh)
    );

    // broadcast capture into every matching unblocked slot
    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) begin
            cap_a[r] = rd_valid && elig_a[r] && (need_a[r] == rd_oh);
            cap_b[r] = rd_valid && elig_b[r] && (need_b[r] == rd_oh);
        end
    end

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        dmx_row #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W)
        ) u_row (
            .clk       (clk),
            .rst_n     (rst_n),
            .iss_en    (iss_en[g]),
            .iss_src_a (iss_src_a),
            .iss_src_b (iss_src_b),
            .iss_dst   (iss_dst),
            .cap_a     (cap_a[g]),
            .cap_b     (cap_b[g]),
            .cap_data  (rd_data),
            .wb_en     (wb_en[g]),
            .kill_en   (kill_en[g]),
            .state_o   (st[g]),
            .need_a_o  (need_a[g]),
            .need_b_o  (need_b[g]),
            .need_wr_o (need_wr[g]),
            .opnd_a_o  (opa[g]),
            .opnd_b_o  (opb[g])
        );
    end

    // column ORs; a releasing row drops its write in the same cycle
    always_comb begin
        pend_wr = '0;
        pend_rd = '0;
        for (int r = 0; r < NUM_ROWS; r++) begin
            pend_wr = pend_wr | (need_wr[r] & {NUM_REGS{~rel[r]}});
            pend_rd = pend_rd | need_a[r] | need_b[r];
        end
    end

    always_comb begin
        for (int r = 0; r < NUM_ROWS; r++) ops_ready[r] = (st[r] == ROW_READY);
    end

    assign sel_opnd_a = opa[sel_row];
    assign sel_opnd_b = opb[sel_row];

endmodule

// File: rtl/dmx_checker.sv
module dmx_checker #(
    parameter int NUM_ROWS = 8,
    parameter int NUM_REGS = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        iss_valid,
    input logic [$clog2(NUM_ROWS)-1:0] iss_row,
    input logic                        wb_valid,
    input logic [$clog2(NUM_ROWS)-1:0] wb_row,
    input logic                        kill_valid,
    input logic [$clog2(NUM_ROWS)-1:0] kill_row,
    input logic                        rd_valid,
    input logic [NUM_REGS-1:0]         rd_oh,
    input logic [NUM_REGS-1:0]         pend_rd,
    input logic [NUM_ROWS-1:0]         ops_ready
);

    p_rd_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($countones(rd_oh) == 1));

    p_rd_needed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_oh & pend_rd) != '0));

    p_idle_no_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_rd == '0) |-> !rd_valid);

    p_wb_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && ops_ready[wb_row]) |=> !ops_ready[$past(wb_row)]);

    p_kill_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_valid |=> !ops_ready[$past(kill_row)]);

    p_busy_issue_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && ops_ready[iss_row] &&
         !(wb_valid && (wb_row == iss_row)) &&
         !(kill_valid && (kill_row == iss_row)))
        |=> ops_ready[$past(iss_row)]);

endmodule

bind fu_reg_depmatrix dmx_checker #(
    .NUM_ROWS (NUM_ROWS),
    .NUM_REGS (NUM_REGS)
) u_dmx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_row    (iss_row),
    .wb_valid   (wb_valid),
    .wb_row     (wb_row),
    .kill_valid (kill_valid),
    .kill_row   (kill_row),
    .rd_valid   (rd_valid),
    .rd_oh      (rd_oh),
    .pend_rd    (pend_rd),
    .ops_ready  (ops_ready)
);

// File: tb/test_fu_reg_depmatrix.sv
module test_fu_reg_depmatrix;

    localparam int NR = 8;
    localparam int NG = 32;
    localparam int DW = 32;
    localparam logic [5:0] NONE = 6'd63;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, wb_valid = 1'b0, kill_valid = 1'b0;
    logic [2:0]    iss_row = '0, wb_row = '0, kill_row = '0, sel_row = '0;
    logic [NG-1:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
    logic          rd_valid;
    logic [NG-1:0] rd_oh, pend_wr, pend_rd;
    logic [DW-1:0] rd_data, sel_opnd_a, sel_opnd_b;
    logic [NR-1:0] ops_ready;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    fu_reg_depmatrix #(.NUM_ROWS(NR), .NUM_REGS(NG), .DATA_W(DW)) i_fu_reg_depmatrix (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_row(iss_row),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_dst(iss_dst),
        .wb_valid(wb_valid), .wb_row(wb_row),
        .kill_valid(kill_valid), .kill_row(kill_row),
        .rd_valid(rd_valid), .rd_oh(rd_oh), .rd_data(rd_data),
        .sel_row(sel_row), .sel_opnd_a(sel_opnd_a), .sel_opnd_b(sel_opnd_b),
        .pend_wr(pend_wr), .pend_rd(pend_rd), .ops_ready(ops_ready)
    );

    // register file model: register k holds C0DE_0000 | k
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NG; k++)
            if (rd_oh[k]) rd_data = 32'hC0DE_0000 | 32'(k);
    end

    function automatic logic [NG-1:0] oh(input logic [5:0] n);
        return (n < 6'd32) ? (NG'(1) << n) : '0;
    endfunction

    function automatic logic [31:0] val(input int k);
        return 32'hC0DE_0000 | 32'(k);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  op;    // 0 issue, 1 writeback, 2 kill
        logic [2:0]  row;
        logic [5:0]  sa;
        logic [5:0]  sb;
        logic [5:0]  d;
        logic [31:0] ewr;
        logic [31:0] erd;
        logic [7:0]  erdy;
        logic [2:0]  srow;
        logic [31:0] ea;
        logic [31:0] eb;
    } step_t;

    localparam int NSTEP = 13;
    localparam step_t STEPS [NSTEP] = '{
        // free sources captured (R2, R6)
        '{2'd0, 3'd0, 6'd1,  6'd2,  6'd3,  32'h0000_0008, 32'h0, 8'h01, 3'd0, 32'hC0DE_0001, 32'hC0DE_0002},
        // source 3 blocked by row 0 (R5)
        '{2'd0, 3'd1, 6'd3,  6'd4,  6'd5,  32'h0000_0028, 32'h0000_0008, 8'h01, 3'd1, 32'h0, 32'hC0DE_0004},
        // both sources blocked, own dst 5 also written by row 1 (R5)
        '{2'd0, 3'd2, 6'd5,  6'd3,  6'd5,  32'h0000_0028, 32'h0000_0028, 8'h01, 3'd2, 32'h0, 32'h0},
        // writeback to a waiting row is ignored (R8)
        '{2'd1, 3'd2, NONE,  NONE,  NONE,  32'h0000_0028, 32'h0000_0028, 8'h01, 3'd2, 32'h0, 32'h0},
        // writeback row 0 frees 3 for rows 1 and 2 at once (R6, R8)
        '{2'd1, 3'd0, NONE,  NONE,  NONE,  32'h0000_0020, 32'h0000_0020, 8'h02, 3'd2, 32'h0, 32'hC0DE_0003},
        // own destination does not block own source (R5)
        '{2'd0, 3'd3, 6'd6,  NONE,  6'd6,  32'h0000_0060, 32'h0000_0020, 8'h0A, 3'd3, 32'hC0DE_0006, 32'h0},
        // kill row 1 unblocks row 2 source 5 (R9)
        '{2'd2, 3'd1, NONE,  NONE,  NONE,  32'h0000_0060, 32'h0, 8'h0C, 3'd2, 32'hC0DE_0005, 32'hC0DE_0003},
        // no sources: ready at once (R7)
        '{2'd0, 3'd4, NONE,  NONE,  6'd0,  32'h0000_0061, 32'h0, 8'h1C, 3'd4, 32'h0, 32'h0},
        // issue to busy row 3 is ignored (R2)
        '{2'd0, 3'd3, 6'd7,  NONE,  6'd8,  32'h0000_0061, 32'h0, 8'h1C, 3'd3, 32'hC0DE_0006, 32'h0},
        // writeback to idle row 5 is ignored (R8)
        '{2'd1, 3'd5, NONE,  NONE,  NONE,  32'h0000_0061, 32'h0, 8'h1C, 3'd4, 32'h0, 32'h0},
        // same register on both sources, one read fills both (R6)
        '{2'd0, 3'd7, 6'd31, 6'd31, 6'd31, 32'h8000_0061, 32'h0, 8'h9C, 3'd7, 32'hC0DE_001F, 32'hC0DE_001F},
        '{2'd1, 3'd2, NONE,  NONE,  NONE,  32'h8000_0041, 32'h0, 8'h98, 3'd3, 32'hC0DE_0006, 32'h0},
        '{2'd2, 3'd7, NONE,  NONE,  NONE,  32'h0000_0041, 32'h0, 8'h18, 3'd4, 32'h0, 32'h0}
    };

    task automatic drive(input logic [1:0] op, input logic [2:0] row,
                         input logic [5:0] sa, input logic [5:0] sb, input logic [5:0] d);
        @(negedge clk);
        case (op)
            2'd0: begin
                iss_valid = 1'b1; iss_row = row;
                iss_src_a = oh(sa); iss_src_b = oh(sb); iss_dst = oh(d);
            end
            2'd1: begin wb_valid = 1'b1; wb_row = row; end
            default: begin kill_valid = 1'b1; kill_row = row; end
        endcase
        @(negedge clk);
        iss_valid = 1'b0; wb_valid = 1'b0; kill_valid = 1'b0;
        iss_src_a = '0; iss_src_b = '0; iss_dst = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 pend_wr", pend_wr, '0);
        chk("R1 pend_rd", pend_rd, '0);
        chk("R1 ops_ready", 32'(ops_ready), '0);
        chk("R1 rd_valid", 32'(rd_valid), '0);

        // table walk: R2, R3, R5, R6, R7, R8, R9 via the comments on each step
        for (int i = 0; i < NSTEP; i++) begin
            drive(STEPS[i].op, STEPS[i].row, STEPS[i].sa, STEPS[i].sb, STEPS[i].d);
            repeat (4) @(negedge clk);
            sel_row = STEPS[i].srow;
            #1;
            chk($sformatf("R3 pend_wr step %0d", i), pend_wr, STEPS[i].ewr);
            chk($sformatf("R3 pend_rd step %0d", i), pend_rd, STEPS[i].erd);
            chk($sformatf("R7 ops_ready step %0d", i), 32'(ops_ready), 32'(STEPS[i].erdy));
            chk($sformatf("R6 operand a step %0d", i), sel_opnd_a, STEPS[i].ea);
            chk($sformatf("R6 operand b step %0d", i), sel_opnd_b, STEPS[i].eb);
        end

        // directed: priority and broadcast after a double release
        do_reset();
        drive(2'd0, 3'd0, NONE, NONE, 6'd20);
        drive(2'd0, 3'd1, NONE, NONE, 6'd21);
        drive(2'd0, 3'd6, 6'd21, NONE, 6'd22);
        drive(2'd0, 3'd5, 6'd20, 6'd21, 6'd23);
        @(negedge clk);
        chk("R5 all blocked rd_valid", 32'(rd_valid), '0);
        chk("R2 pend_rd", pend_rd, oh(6'd20) | oh(6'd21));
        wb_valid = 1'b1; wb_row = 3'd1;
        kill_valid = 1'b1; kill_row = 3'd0;
        #1;
        chk("R8 R9 same-cycle pend_wr drop", pend_wr, oh(6'd22) | oh(6'd23));
        @(negedge clk);
        wb_valid = 1'b0; kill_valid = 1'b0;
        chk("R4 rd_valid", 32'(rd_valid), 32'd1);
        chk("R4 lowest row first", rd_oh, oh(6'd20));
        @(negedge clk);
        chk("R6 shared read", rd_oh, oh(6'd21));
        @(negedge clk);
        chk("R4 no request left", 32'(rd_valid), '0);
        chk("R7 both ready", 32'(ops_ready), 32'h60);
        sel_row = 3'd5; #1;
        chk("R6 row5 a", sel_opnd_a, val(20));
        chk("R6 row5 b", sel_opnd_b, val(21));
        sel_row = 3'd6; #1;
        chk("R6 row6 a", sel_opnd_a, val(21));

        // kill of a waiting row drops its reads on the next cycle
        drive(2'd0, 3'd2, 6'd22, NONE, NONE);
        chk("R9 blocked read visible", pend_rd, oh(6'd22));
        drive(2'd2, 3'd2, NONE, NONE, NONE);
        chk("R9 read dropped", pend_rd, '0);
        chk("R9 pend_wr kept", pend_wr, oh(6'd22) | oh(6'd23));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule